// File: doc/BRIEF.md
# Symbol-Pair Framer with Guarded Reframing

This block sits behind the bit-level receiver of a 4B/5B line and finds where 10-bit symbol pairs begin. Each clock it shifts in one received bit. It compares the newest ten bits against the start delimiter pair (J = 11000 followed by K = 10001) and against the two halt-based pairs. Through a phase counter it keeps a current pair boundary and strobes an aligned pair out whenever a boundary is reached.

A delimiter pair does not always move the boundary. A line-state input from an external detector decides which rules apply. While that input says Idle, any J-K realigns at once. While it says Active, a J-K realigns only when it is far enough from the last accepted one. It must also either fall on the current boundary or follow an Idle or Ending Delimiter indication. Off-boundary halt pairs seen during an active frame are reported as violations and leave the alignment alone. A hold input freezes the boundary completely.

Top module: `frm_pair_aligner`

## Requirements
- R1: Pairs are assembled first-bit-first. The earliest received bit of a pair appears at `pair_o[9]`. The start delimiter is the ten-bit value 1100010001.
- R2: With `line_active_i` low, a start delimiter completing at any bit offset is accepted. `realign_o` pulses together with `pair_vld_o`, `pair_o` carries the delimiter, and later pairs are counted from that point.
- R3: Between realignments, `pair_vld_o` pulses exactly once every 10 bits. `pair_o` then holds the ten most recent bits and keeps that value until the next strobe.
- R4: With `line_active_i` high, an on-boundary start delimiter is accepted only if it completes at least GAP_MIN (default 30) bits after the last accepted delimiter completed.
- R5: With `line_active_i` high, once a delimiter has been accepted, an off-boundary start delimiter is not accepted, however far it lies from the last one. `jk_off_o` pulses for every start delimiter seen off the current boundary.
- R6: A pulse on `idle_t_i` while `line_active_i` is high allows the next start delimiter to be accepted on or off boundary, subject to R4 spacing. The permission is used up by the next acceptance.
- R7: With `line_active_i` high and a delimiter accepted since the line was last Idle, an off-boundary halt pair pulses `viol_o` and does not realign. The halt pairs are 0010000100 and 0010000000.
- R8: With `line_active_i` low, halt pairs raise no violation and do not stop a later start delimiter from being accepted.
- R9: While `hold_i` is high, no delimiter is accepted and the boundary is kept. Acceptance resumes once it is released.
- R10: After reset all outputs are 0. The first pair strobe follows the tenth bit received after reset.
- R11: Outputs are registered. A strobe caused by the bit sampled at clock edge n is visible after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received serial bit, one per clock |
| line_active_i | input | 1 | Line state from the detector: 1 Active, 0 Idle |
| idle_t_i | input | 1 | Pulse: Idle symbol or Ending Delimiter received |
| hold_i | input | 1 | Freeze the current alignment |
| pair_o | output | 10 | Last aligned symbol pair, first bit in bit 9 |
| pair_vld_o | output | 1 | Pair strobe |
| realign_o | output | 1 | A start delimiter was accepted and the boundary moved to it |
| jk_off_o | output | 1 | Start delimiter seen off the current boundary |
| viol_o | output | 1 | Off-boundary halt pair inside an active frame |

## Verification
The stream starts with delimiters in the Idle state at an arbitrary offset, which separates free alignment from gated alignment. On-boundary delimiters are then sent 20 and 30 bits after an acceptance, which locates the spacing threshold exactly. An off-boundary delimiter far beyond the threshold is sent both without and with a preceding Idle/Ending Delimiter pulse, which shows that the permission flag alone decides the outcome. Halt pairs at off-boundary offsets are sent in Active and in Idle, and a delimiter is offered under hold and then after release. Each outcome is compared cycle by cycle against a behavioural model and counted against hand-derived pulse totals.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int SYM_W  = 5;
  localparam int PAIR_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_H = 5'b00100;
  localparam logic [SYM_W-1:0] SYM_Q = 5'b00000;

  typedef enum logic [1:0] {
    PAT_JK = 2'd0,
    PAT_HH = 2'd1,
    PAT_HQ = 2'd2
  } pat_e;

  localparam int NPAT = 3;

  localparam logic [PAIR_W-1:0] PAIR_JK = {SYM_J, SYM_K};

  function automatic logic [PAIR_W-1:0] pat_val(input int idx);
    case (idx)
      0:       return {SYM_J, SYM_K};
      1:       return {SYM_H, SYM_H};
      default: return {SYM_H, SYM_Q};
    endcase
  endfunction
endpackage

// File: rtl/frm_window.sv
module frm_window
  import frm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  output logic [PAIR_W-1:0] win_o,
  output logic [NPAT-1:0]   hit_o
);
  logic [PAIR_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= {win_q[PAIR_W-2:0], bit_i};
  end

  assign win_o = win_q;

  // one comparator per delimiter pattern; shifting covers every offset
  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    assign hit_o[g] = (win_q == pat_val(g));
  end
endmodule

// File: rtl/frm_timing.sv
module frm_timing #(
  parameter int PAIR_W  = 10,
  parameter int GAP_MIN = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  output logic on_bnd_o,
  output logic gap_ok_o
);
  localparam int PH_W  = $clog2(PAIR_W + 1);
  localparam int GAP_W = $clog2(GAP_MIN + 1) < 1 ? 1 : $clog2(GAP_MIN + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(GAP_MIN);
  localparam logic [PH_W-1:0]  PH_END  = PH_W'(PAIR_W);

  logic [PH_W-1:0]  ph_q;   // bits of the current pair already received
  logic [GAP_W-1:0] gap_q;  // bits since last accepted delimiter, saturating

  assign on_bnd_o = (ph_q == PH_END);
  assign gap_ok_o = (gap_q >= GAP_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      gap_q <= GAP_LIM;
    end else begin
      if (accept_i || on_bnd_o) ph_q <= PH_W'(1);
      else                      ph_q <= ph_q + 1'b1;
      if (accept_i)             gap_q <= GAP_W'(1);
      else if (!gap_ok_o)       gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/frm_policy.sv
module frm_policy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_active_i,
  input  logic idle_t_i,
  input  logic hold_i,
  input  logic jk_hit_i,
  input  logic halt_hit_i,
  input  logic on_bnd_i,
  input  logic gap_ok_i,
  output logic accept_o,
  output logic viol_o
);
  logic open_q;   // idle/ending delimiter seen since last acceptance
  logic armed_q;  // delimiter accepted since line was last Idle
  logic pass_active;

  assign pass_active = gap_ok_i && (on_bnd_i || open_q);
  assign accept_o    = jk_hit_i && !hold_i && (!line_active_i || pass_active);
  assign viol_o      = halt_hit_i && !on_bnd_i && line_active_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (accept_o)      open_q <= 1'b0;
      else if (idle_t_i) open_q <= 1'b1;
      if (accept_o)           armed_q <= 1'b1;
      else if (!line_active_i) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frm_pair_aligner.sv
module frm_pair_aligner
  import frm_pkg::*;
#(
  parameter int GAP_MIN = 3 * PAIR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              line_active_i,
  input  logic              idle_t_i,
  input  logic              hold_i,
  output logic [PAIR_W-1:0] pair_o,
  output logic              pair_vld_o,
  output logic              realign_o,
  output logic              jk_off_o,
  output logic              viol_o
);
  logic [PAIR_W-1:0] win;
  logic [NPAT-1:0]   hit;
  logic              on_bnd, gap_ok, accept, viol, halt_hit, strobe;

  frm_window i_window (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .win_o (win),
    .hit_o (hit)
  );

  frm_timing #(
    .PAIR_W (PAIR_W),
    .GAP_MIN(GAP_MIN)
  ) i_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .on_bnd_o(on_bnd),
    .gap_ok_o(gap_ok)
  );

  assign halt_hit = hit[PAT_HH] | hit[PAT_HQ];

  frm_policy i_policy (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_active_i(line_active_i),
    .idle_t_i     (idle_t_i),
    .hold_i       (hold_i),
    .jk_hit_i     (hit[PAT_JK]),
    .halt_hit_i   (halt_hit),
    .on_bnd_i     (on_bnd),
    .gap_ok_i     (gap_ok),
    .accept_o     (accept),
    .viol_o       (viol)
  );

  assign strobe = on_bnd | accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_o     <= '0;
      pair_vld_o <= 1'b0;
      realign_o  <= 1'b0;
      jk_off_o   <= 1'b0;
      viol_o     <= 1'b0;
    end else begin
      if (strobe) pair_o <= win;
      pair_vld_o <= strobe;
      realign_o  <= accept;
      jk_off_o   <= hit[PAT_JK] & ~on_bnd;
      viol_o     <= viol;
    end
  end
endmodule

// File: rtl/frm_aligner_chk.sv
module frm_aligner_chk
  import frm_pkg::*;
#(
  parameter int GAP_MIN = 3 * PAIR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              line_active_i,
  input logic              hold_i,
  input logic [PAIR_W-1:0] pair_o,
  input logic              pair_vld_o,
  input logic              realign_o,
  input logic              viol_o
);
  localparam int RW = $clog2(GAP_MIN + 2);
  localparam int PW = $clog2(PAIR_W + 2);

  logic [RW-1:0] since_rl_q;
  logic [PW-1:0] since_pv_q;
  logic          seen_pv_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rl_q <= RW'(GAP_MIN);
      since_pv_q <= '0;
      seen_pv_q  <= 1'b0;
      act_q      <= 1'b0;
    end else begin
      act_q <= line_active_i;
      if (realign_o)                       since_rl_q <= RW'(1);
      else if (since_rl_q < RW'(GAP_MIN))  since_rl_q <= since_rl_q + 1'b1;
      if (pair_vld_o) begin
        since_pv_q <= PW'(1);
        seen_pv_q  <= 1'b1;
      end else if (since_pv_q <= PW'(PAIR_W)) begin
        since_pv_q <= since_pv_q + 1'b1;
      end
    end
  end

  p_realign_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> (pair_o == PAIR_JK));

  p_realign_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> pair_vld_o);

  p_pair_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_vld_o && !realign_o && seen_pv_q) |-> (since_pv_q == PW'(PAIR_W)));

  p_gap_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (realign_o && act_q) |-> (since_rl_q >= RW'(GAP_MIN)));

  p_viol_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> act_q);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !realign_o);
endmodule

bind frm_pair_aligner frm_aligner_chk #(
  .GAP_MIN(GAP_MIN)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_active_i(line_active_i),
  .hold_i       (hold_i),
  .pair_o       (pair_o),
  .pair_vld_o   (pair_vld_o),
  .realign_o    (realign_o),
  .viol_o       (viol_o)
);

// File: tb/test_frm_pair_aligner.sv
`timescale 1ns/1ps
module test_frm_pair_aligner;
  localparam int GAP = 30;
  localparam logic [4:0] S_J = 5'b11000, S_K = 5'b10001, S_H = 5'b00100,
                         S_Q = 5'b00000, S_D = 5'b10101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_i = 1'b1, act = 1'b0, idle_t = 1'b0, hold = 1'b0;
  logic [9:0] pair_o;
  logic pair_vld_o, realign_o, jk_off_o, viol_o;

  always #2.5 clk = ~clk;

  frm_pair_aligner #(.GAP_MIN(GAP)) i_frm_pair_aligner (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_i), .line_active_i(act),
    .idle_t_i(idle_t), .hold_i(hold), .pair_o(pair_o), .pair_vld_o(pair_vld_o),
    .realign_o(realign_o), .jk_off_o(jk_off_o), .viol_o(viol_o));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int actv, input int expv);
    n_chk++;
    if (actv != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actv, expv, $time);
    end
  endtask

  // behavioural reference
  int m_win = 0, m_cnt = 0, m_gap = GAP;
  bit m_open = 0, m_armed = 0;
  int e_pair = 0;
  bit e_vld = 0, e_rl = 0, e_off = 0, e_viol = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_cnt = 0; m_gap = GAP; m_open = 0; m_armed = 0;
      e_pair = 0; e_vld = 0; e_rl = 0; e_off = 0; e_viol = 0;
    end else begin
      bit bnd, jk, hl, acc;
      bnd = (m_cnt == 10);
      jk  = (m_win == 10'b1100010001);
      hl  = (m_win == 10'b0010000100) || (m_win == 10'b0010000000);
      acc = jk && !hold && (!act || (m_gap >= GAP && (bnd || m_open)));
      e_vld  = bnd || acc;
      if (e_vld) e_pair = m_win;
      e_rl   = acc;
      e_off  = jk && !bnd;
      e_viol = hl && !bnd && act && m_armed;
      m_cnt  = (acc || bnd) ? 1 : m_cnt + 1;
      m_gap  = acc ? 1 : ((m_gap < GAP) ? m_gap + 1 : GAP);
      if (acc) m_open = 0; else if (idle_t) m_open = 1;
      if (acc) m_armed = 1; else if (!act) m_armed = 0;
      m_win = ((m_win << 1) | int'(bit_i)) & 10'h3FF;
    end
  end

  int rl_cnt = 0, viol_cnt = 0, off_cnt = 0;
  logic [9:0] rl_pair = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R11 pair_vld_o", int'(pair_vld_o), int'(e_vld));
      chk("R1 R3 pair_o", int'(pair_o), e_pair);
      chk("R2 realign_o", int'(realign_o), int'(e_rl));
      chk("R5 jk_off_o", int'(jk_off_o), int'(e_off));
      chk("R7 viol_o", int'(viol_o), int'(e_viol));
      if (realign_o) begin rl_cnt++; rl_pair = pair_o; end
      if (viol_o) viol_cnt++;
      if (jk_off_o) off_cnt++;
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i = b;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_sym(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) send_bit(s[i]);
  endtask

  task automatic send_jk();
    send_sym(S_J);
    send_sym(S_K);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int r0, v0, o0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset values
    chk("R10 pair_vld_o reset", int'(pair_vld_o), 0);
    chk("R10 realign_o reset", int'(realign_o), 0);
    chk("R10 viol_o reset", int'(viol_o), 0);
    chk("R10 pair_o reset", int'(pair_o), 0);
    send_ones(12);

    // S1: Idle, delimiter at arbitrary offset
    r0 = rl_cnt;
    send_ones(3); send_jk(); send_ones(5);
    chk("R2 idle accept count", rl_cnt - r0, 1);
    chk("R1 realign pair value", int'(rl_pair), 10'b1100010001);
    act = 1'b1;

    // S2: on-boundary at 20 bits rejected, at 30 accepted
    r0 = rl_cnt;
    send_ones(5); send_jk(); send_jk(); send_ones(5);
    chk("R4 spacing accept count", rl_cnt - r0, 1);

    // S3: off-boundary far beyond spacing, ignored
    r0 = rl_cnt; o0 = off_cnt;
    for (int i = 0; i < 6; i++) send_sym(S_D);
    send_ones(3); send_jk(); send_ones(5);
    chk("R5 off-boundary ignored", rl_cnt - r0, 0);
    chk("R5 off-boundary flagged", off_cnt - o0, 1);

    // S4: idle/ending delimiter pulse opens off-boundary acceptance
    r0 = rl_cnt;
    @(negedge clk); bit_i = 1'b1; idle_t = 1'b1;
    @(negedge clk); bit_i = 1'b1; idle_t = 1'b0;
    send_ones(2); send_jk(); send_ones(5);
    chk("R6 reopened accept count", rl_cnt - r0, 1);

    // S5: off-boundary halt pairs inside active frame
    r0 = rl_cnt; v0 = viol_cnt;
    send_ones(3); send_sym(S_H); send_sym(S_H);
    send_ones(3); send_sym(S_H); send_sym(S_Q);
    send_ones(5);
    chk("R7 halt violations", viol_cnt - v0, 2);
    chk("R7 halt no realign", rl_cnt - r0, 0);

    // S6: Idle, halt pair then on-boundary delimiter
    act = 1'b0;
    r0 = rl_cnt; v0 = viol_cnt;
    send_ones(4); send_sym(S_H); send_sym(S_H); send_jk(); send_ones(5);
    chk("R8 idle halt no violation", viol_cnt - v0, 0);
    chk("R8 idle halt then accept", rl_cnt - r0, 1);

    // S7: hold blocks realignment
    hold = 1'b1;
    r0 = rl_cnt;
    send_ones(3); send_jk(); send_ones(5);
    chk("R9 hold blocks", rl_cnt - r0, 0);
    hold = 1'b0;

    // S8: after release, acceptance resumes
    r0 = rl_cnt;
    send_ones(2); send_jk(); send_ones(5);
    chk("R9 release accept", rl_cnt - r0, 1);
    chk("R1 realign pair after release", int'(rl_pair), 10'b1100010001);

    send_ones(10);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule